// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers seven interrupt sources of a peripheral into one active-low request to the processor. Each source delivers a one-cycle event pulse. The pulse latches into a pending flag, and that flag stays set until software removes it. A seven-bit enable mask chooses which pending flags may raise the request. The processor reaches both registers through a small register port made of a chip select, a register select, a read/write strobe and an 8-bit data bus. The top bit of each register is not storage. In the flag register it reads back a live summary of enabled pending work. In the enable register it selects whether a write sets or clears the marked enable bits.

Port-side logic outside this block can request a flag clear as a side effect of a port data register access. Each source has an "independent" qualifier that protects its flag from that side-effect clear. A source in independent mode can only be cleared by software writing a 1 into the flag register. The request output is modelled for a shared open-drain line: one pin carries the low level and a second pin enables the driver.

Top module: `intr_agg_top`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears all flags and all enables. After reset the flag register reads 0x00, the enable register reads 0x80, irq_n is 1 and irq_oe is 0.
- R2: A 1 on src_event[i] at a rising edge sets flag i. The flag then stays set until one of the clears in R3 or R9 removes it.
- R3: A write to the flag register (reg_sel = 0) clears every flag i whose wdata[i] is 1. Flags whose data bit is 0 keep their value.
- R4: A read of the flag register returns the flags in bits 6..0. Bit 7 is the OR over all i of (flag i AND enable i). Writing a 1 to bit 7 of the flag register changes nothing.
- R5: A write to the enable register (reg_sel = 1) with wdata[7] = 1 sets enable i for every wdata[i] that is 1. Every other enable keeps its value.
- R6: A write to the enable register with wdata[7] = 0 clears enable i for every wdata[i] that is 1. Every other enable keeps its value.
- R7: A read of the enable register returns 1 in bit 7 and the current enables in bits 6..0.
- R8: irq_n is 0 and irq_oe is 1 exactly when the summary of R4 is 1. Otherwise irq_n is 1 and irq_oe is 0.
- R9: port_clr[i] at a rising edge clears flag i only when indep[i] is 0. When indep[i] is 1, the flag keeps its value.
- R10: When src_event[i] arrives in the same cycle as a software clear or a port clear of flag i, the flag ends set.
- R11: With cs low, writes have no effect and rdata is 0x00. rdata is also 0x00 during any write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| rnw | input | 1 | 1 = read, 0 = write |
| reg_sel | input | 1 | 0 = flag register, 1 = enable register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| src_event | input | 7 | Per-source event pulses |
| port_clr | input | 7 | Per-source side-effect clear requests |
| indep | input | 7 | Per-source independent-mode qualifier |
| irq_n | output | 1 | Active-low interrupt request level |
| irq_oe | output | 1 | Driver enable for the shared request line |

## Verification
The hardest situation to reach from the ports is a collision on one flag: an event pulse and a clear land on the same bit in the same cycle. The stimulus builds this collision twice, once with a software flag-register write and once with a port-side clear request, and then reads the flag back. A second hard case is a flag that should survive a port-side clear because its source is in independent mode. The bench first raises the flag, then sends the clear with the qualifier set, then sends it again without the qualifier, and reads the flag register after each step. The bench also drives a write with cs low and then reads back the enables, which shows that the write was ignored.

// File: rtl/intr_agg_pkg.sv
// Package: shared constants and types for the interrupt aggregation block.
// Assumes the data bus is one bit wider than the number of sources.
package intr_agg_pkg;

    localparam int unsigned SRC_DEFAULT = 7;

    // Register select encoding on the reg_sel pin
    typedef enum logic {
        SEL_FLAGS   = 1'b0,
        SEL_ENABLES = 1'b1
    } intr_sel_e;

endpackage

// File: rtl/intr_agg_decode.sv
// Module: intr_agg_decode
// Turns the register-port strobes into per-register actions: the software
// clear mask for the flags, the write strobe and direction for the enables,
// and the two read selects. Purely combinational.
// Assumes: DW = NSRC + 1. Bit NSRC of wdata is the control bit.
module intr_agg_decode
    import intr_agg_pkg::*;
#(
    parameter int unsigned NSRC = SRC_DEFAULT,
    localparam int unsigned DW  = NSRC + 1
) (
    input  logic            cs,
    input  logic            rnw,
    input  logic            reg_sel,
    input  logic [DW-1:0]   wdata,
    output logic [NSRC-1:0] sw_clr,
    output logic            en_wr,
    output logic            en_set,
    output logic [NSRC-1:0] en_mask,
    output logic            rd_flags,
    output logic            rd_enables
);

    logic wr_cyc;
    logic rd_cyc;

    // Qualify the bus cycle type with the chip select
    always_comb begin
        wr_cyc = cs && !rnw;
        rd_cyc = cs && rnw;
    end

    // Flag-register write: low data bits form the clear mask, control bit ignored
    always_comb begin
        sw_clr = (wr_cyc && (reg_sel == SEL_FLAGS)) ? wdata[NSRC-1:0] : '0;
    end

    // Enable-register write: strobe, direction from the control bit, and bit mask
    always_comb begin
        en_wr   = wr_cyc && (reg_sel == SEL_ENABLES);
        en_set  = wdata[NSRC];
        en_mask = wdata[NSRC-1:0];
    end

    // Read selects for the output mux
    always_comb begin
        rd_flags   = rd_cyc && (reg_sel == SEL_FLAGS);
        rd_enables = rd_cyc && (reg_sel == SEL_ENABLES);
    end

endmodule

// File: rtl/intr_agg_flags.sv
// Module: intr_agg_flags
// Holds one pending flag per source. An event sets the flag. A software
// clear or a port-side clear resets it; the port clear is ignored for
// sources in independent mode. A set in the same cycle beats any clear.
// Assumes: events, clears and qualifiers are synchronous to clk.
module intr_agg_flags
    import intr_agg_pkg::*;
#(
    parameter int unsigned NSRC = SRC_DEFAULT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_event,
    input  logic [NSRC-1:0] sw_clr,
    input  logic [NSRC-1:0] port_clr,
    input  logic [NSRC-1:0] indep,
    output logic [NSRC-1:0] flags
);

    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        logic clr_any;

        // Combine the software clear with the port clear when it is allowed
        always_comb begin
            clr_any = sw_clr[g] || (port_clr[g] && !indep[g]);
        end

        // Per-source flag: reset, then set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else if (src_event[g]) begin
                flags[g] <= 1'b1;
            end else if (clr_any) begin
                flags[g] <= 1'b0;
            end
        end
    end

    // R1: flags are empty in the first cycle after reset
    a_r1_flags_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flags == '0));

    // R2 and R10: an event always leaves its flag set, whatever clear arrived with it
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_event) |=> ((flags & $past(src_event)) == $past(src_event)));

    // R2: a set flag drops only through a clear that was allowed to act
    a_r2_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(flags) & ~$past(sw_clr) & ~$past(port_clr & ~indep)) & ~flags) == '0));

    // R3: a software clear with no competing event empties the flag
    a_r3_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sw_clr & ~src_event)) |=> ((flags & $past(sw_clr & ~src_event)) == '0));

    // R9: an allowed port clear with no competing event empties the flag
    a_r9_port_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|(port_clr & ~indep & ~src_event)) |=>
            ((flags & $past(port_clr & ~indep & ~src_event)) == '0));

endmodule

// File: rtl/intr_agg_enables.sv
// Module: intr_agg_enables
// Holds the per-source enable mask. A write marks bits through a mask;
// the direction input decides whether the marked bits are set or cleared.
// Unmarked bits keep their value.
// Assumes: en_wr lasts one cycle per bus write.
module intr_agg_enables
    import intr_agg_pkg::*;
#(
    parameter int unsigned NSRC = SRC_DEFAULT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_wr,
    input  logic            en_set,
    input  logic [NSRC-1:0] en_mask,
    output logic [NSRC-1:0] enables
);

    logic [NSRC-1:0] en_next;

    // Next mask: OR in the marked bits, or AND them out
    always_comb begin
        en_next = en_set ? (enables | en_mask) : (enables & ~en_mask);
    end

    // Enable storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enables <= '0;
        end else if (en_wr) begin
            enables <= en_next;
        end
    end

    // R5: a set-direction write leaves every marked bit at 1 and others untouched
    a_r5_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && en_set) |=>
            (((enables & $past(en_mask)) == $past(en_mask)) &&
             ((enables & ~$past(en_mask)) == ($past(enables) & ~$past(en_mask)))));

    // R6: a clear-direction write leaves every marked bit at 0 and others untouched
    a_r6_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !en_set) |=>
            (((enables & $past(en_mask)) == '0) &&
             ((enables & ~$past(en_mask)) == ($past(enables) & ~$past(en_mask)))));

    // R11: no write strobe, no change
    a_r11_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(enables));

endmodule

// File: rtl/intr_agg_drive.sv
// Module: intr_agg_drive
// Forms the summary of enabled pending flags. It drives the request as a
// low level plus a driver enable, so that an open-drain pad can be built
// around it. Combinational, so the request follows the registers directly.
// Assumes: the pad pulls the line high when irq_oe is 0.
module intr_agg_drive
    import intr_agg_pkg::*;
#(
    parameter int unsigned NSRC = SRC_DEFAULT
) (
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] enables,
    output logic            summary,
    output logic            irq_n,
    output logic            irq_oe
);

    // Any source that is both pending and enabled raises the summary
    always_comb begin
        summary = |(flags & enables);
    end

    // Open-drain model: pull low and enable the driver only while active
    always_comb begin
        irq_n  = !summary;
        irq_oe = summary;
    end

endmodule

// File: rtl/intr_agg_top.sv
// Module: intr_agg_top
// Interrupt aggregation for NSRC sources: pending flags, an enable mask,
// a register port and an active-low request. Register 0 holds the flags
// (write 1 to clear, top bit reads the summary). Register 1 holds the
// enables (the top bit picks set or clear on write and reads as 1).
// Assumes: all inputs are synchronous to clk; rdata is combinational.
module intr_agg_top
    import intr_agg_pkg::*;
#(
    parameter int unsigned NSRC = SRC_DEFAULT,
    localparam int unsigned DW  = NSRC + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs,
    input  logic            rnw,
    input  logic            reg_sel,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [NSRC-1:0] src_event,
    input  logic [NSRC-1:0] port_clr,
    input  logic [NSRC-1:0] indep,
    output logic            irq_n,
    output logic            irq_oe
);

    logic [NSRC-1:0] sw_clr;
    logic            en_wr;
    logic            en_set;
    logic [NSRC-1:0] en_mask;
    logic            rd_flags;
    logic            rd_enables;
    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] enables;
    logic            summary;

    intr_agg_decode #(.NSRC(NSRC)) u_decode (
        .cs         (cs),
        .rnw        (rnw),
        .reg_sel    (reg_sel),
        .wdata      (wdata),
        .sw_clr     (sw_clr),
        .en_wr      (en_wr),
        .en_set     (en_set),
        .en_mask    (en_mask),
        .rd_flags   (rd_flags),
        .rd_enables (rd_enables)
    );

    intr_agg_flags #(.NSRC(NSRC)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_event (src_event),
        .sw_clr    (sw_clr),
        .port_clr  (port_clr),
        .indep     (indep),
        .flags     (flags)
    );

    intr_agg_enables #(.NSRC(NSRC)) u_enables (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_wr   (en_wr),
        .en_set  (en_set),
        .en_mask (en_mask),
        .enables (enables)
    );

    intr_agg_drive #(.NSRC(NSRC)) u_drive (
        .flags   (flags),
        .enables (enables),
        .summary (summary),
        .irq_n   (irq_n),
        .irq_oe  (irq_oe)
    );

    // Read mux: summary over the flags, constant 1 over the enables, else zero
    always_comb begin
        if (rd_flags) begin
            rdata = {summary, flags};
        end else if (rd_enables) begin
            rdata = {1'b1, enables};
        end else begin
            rdata = '0;
        end
    end

    // R4: the top bit of a flag read agrees with the request pin
    a_r4_summary_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rnw && (reg_sel == SEL_FLAGS)) |-> (rdata[NSRC] == !irq_n));

    // R7: the top bit of an enable read is always 1
    a_r7_enable_top: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rnw && (reg_sel == SEL_ENABLES)) |-> rdata[NSRC]);

    // R8: the driver enable is active exactly while the line is pulled low
    a_r8_drive_pair: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe == !irq_n);

    // R11: nothing appears on the data bus outside a selected read
    a_r11_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rnw) |-> (rdata == '0));

endmodule

// File: tb/test_intr_agg_top.sv
// Bench for intr_agg_top. A vector table drives one bus cycle per clock.
// Then directed tests cover bus deselect, a mid-run reset and the pin pair.
module test_intr_agg_top;

    localparam int NSRC = 7;
    localparam int DW   = NSRC + 1;
    // Vector: cs, rnw, sel, data[8], evt[7], pclr[7], indep[7], exp_rd[8], exp_irqn
    localparam int VW   = 1 + 1 + 1 + 8 + 7 + 7 + 7 + 8 + 1;
    localparam int NVEC = 24;

    localparam logic [VW-1:0] VEC [NVEC] = '{
        // R1: flags read 0 after reset
        {1'b1, 1'b1, 1'b0, 8'h00, 7'h00, 7'h00, 7'h00, 8'h00, 1'b1},
        // R1 R7: enables read 0x80 after reset
        {1'b1, 1'b1, 1'b1, 8'h00, 7'h00, 7'h00, 7'h00, 8'h80, 1'b1},
        // R2: events on sources 0 and 2
        {1'b0, 1'b1, 1'b0, 8'h00, 7'h05, 7'h00, 7'h00, 8'h00, 1'b1},
        // R2 R4: flags pending but not enabled
        {1'b1, 1'b1, 1'b0, 8'h00, 7'h00, 7'h00, 7'h00, 8'h05, 1'b1},
        // R5: set enables 0 and 1
        {1'b1, 1'b0, 1'b1, 8'h83, 7'h00, 7'h00, 7'h00, 8'h00, 1'b1},
        // R4 R8: summary now active
        {1'b1, 1'b1, 1'b0, 8'h00, 7'h00, 7'h00, 7'h00, 8'h85, 1'b0},
        // R5 R7: enables read back
        {1'b1, 1'b1, 1'b1, 8'h00, 7'h00, 7'h00, 7'h00, 8'h83, 1'b0},
        // R4: write only the top bit of the flag register
        {1'b1, 1'b0, 1'b0, 8'h80, 7'h00, 7'h00, 7'h00, 8'h00, 1'b0},
        // R4: flags unchanged by it
        {1'b1, 1'b1, 1'b0, 8'h00, 7'h00, 7'h00, 7'h00, 8'h85, 1'b0},
        // R6: clear enable 0
        {1'b1, 1'b0, 1'b1, 8'h01, 7'h00, 7'h00, 7'h00, 8'h00, 1'b0},
        // R6 R8: summary gone, flags kept
        {1'b1, 1'b1, 1'b0, 8'h00, 7'h00, 7'h00, 7'h00, 8'h05, 1'b1},
        // R6: enables now 0x82
        {1'b1, 1'b1, 1'b1, 8'h00, 7'h00, 7'h00, 7'h00, 8'h82, 1'b1},
        // R3: clear flag 0
        {1'b1, 1'b0, 1'b0, 8'h01, 7'h00, 7'h00, 7'h00, 8'h00, 1'b1},
        // R3: only flag 2 remains
        {1'b1, 1'b1, 1'b0, 8'h00, 7'h00, 7'h00, 7'h00, 8'h04, 1'b1},
        // R10: event 1 against a software clear of flag 1
        {1'b1, 1'b0, 1'b0, 8'h02, 7'h02, 7'h00, 7'h00, 8'h00, 1'b1},
        // R10: flag 1 set, enabled, summary on
        {1'b1, 1'b1, 1'b0, 8'h00, 7'h00, 7'h00, 7'h00, 8'h86, 1'b0},
        // R9: port clear on flag 2 in independent mode
        {1'b0, 1'b1, 1'b0, 8'h00, 7'h00, 7'h04, 7'h04, 8'h00, 1'b0},
        // R9: flag 2 kept
        {1'b1, 1'b1, 1'b0, 8'h00, 7'h00, 7'h00, 7'h00, 8'h86, 1'b0},
        // R9: port clear on flag 2, not independent
        {1'b0, 1'b1, 1'b0, 8'h00, 7'h00, 7'h04, 7'h00, 8'h00, 1'b0},
        // R9: flag 2 cleared
        {1'b1, 1'b1, 1'b0, 8'h00, 7'h00, 7'h00, 7'h00, 8'h82, 1'b0},
        // R10: event 1 against a port clear of flag 1
        {1'b0, 1'b1, 1'b0, 8'h00, 7'h02, 7'h02, 7'h00, 8'h00, 1'b0},
        // R10: flag 1 still set
        {1'b1, 1'b1, 1'b0, 8'h00, 7'h00, 7'h00, 7'h00, 8'h82, 1'b0},
        // R3: clear all flags
        {1'b1, 1'b0, 1'b0, 8'h7F, 7'h00, 7'h00, 7'h00, 8'h00, 1'b0},
        // R3 R8: all clear, request released
        {1'b1, 1'b1, 1'b0, 8'h00, 7'h00, 7'h00, 7'h00, 8'h00, 1'b1}
    };

    logic            clk;
    logic            rst_n;
    logic            cs;
    logic            rnw;
    logic            reg_sel;
    logic [DW-1:0]   wdata;
    logic [DW-1:0]   rdata;
    logic [NSRC-1:0] src_event;
    logic [NSRC-1:0] port_clr;
    logic [NSRC-1:0] indep;
    logic            irq_n;
    logic            irq_oe;

    int n_cmp;
    int n_bad;
    bit done;

    intr_agg_top #(.NSRC(NSRC)) i_intr_agg_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .rnw       (rnw),
        .reg_sel   (reg_sel),
        .wdata     (wdata),
        .rdata     (rdata),
        .src_event (src_event),
        .port_clr  (port_clr),
        .indep     (indep),
        .irq_n     (irq_n),
        .irq_oe    (irq_oe)
    );

    // 100 MHz clock
    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Compare one value and report a mismatch
    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one bus cycle at the falling edge
    task automatic drive(input logic c, input logic r, input logic s, input logic [7:0] d,
                         input logic [6:0] e, input logic [6:0] p, input logic [6:0] q);
        @(negedge clk);
        cs = c; rnw = r; reg_sel = s; wdata = d;
        src_event = e; port_clr = p; indep = q;
    endtask

    // Return the bus to idle for one cycle
    task automatic idle();
        drive(1'b0, 1'b1, 1'b0, 8'h00, 7'h00, 7'h00, 7'h00);
    endtask

    // Print the summary once and stop
    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #200_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Stimulus and checks
    initial begin
        n_cmp = 0; n_bad = 0; done = 1'b0;
        rst_n = 1'b0; cs = 1'b0; rnw = 1'b1; reg_sel = 1'b0; wdata = '0;
        src_event = '0; port_clr = '0; indep = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: pins after reset
        #3;
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        check("R1 irq_oe", {7'd0, irq_oe}, 8'h00);

        // Table walk: sample in the cycle, before the edge that applies it
        for (int v = 0; v < NVEC; v++) begin
            logic [VW-1:0] t;
            t = VEC[v];
            drive(t[40], t[39], t[38], t[37:30], t[29:23], t[22:16], t[15:9]);
            #3;
            if (t[40] && t[39]) begin
                check($sformatf("vec %0d rdata", v), rdata, t[8:1]);
            end
            check($sformatf("vec %0d R8 irq_n", v), {7'd0, irq_n}, {7'd0, t[0]});
            check($sformatf("vec %0d R8 irq_oe", v), {7'd0, irq_oe}, {7'd0, ~t[0]});
        end

        // R11: a deselected enable write is ignored and the bus stays 0
        drive(1'b0, 1'b0, 1'b1, 8'hFF, 7'h00, 7'h00, 7'h00);
        #3;
        check("R11 rdata deselected", rdata, 8'h00);
        drive(1'b1, 1'b1, 1'b1, 8'h00, 7'h00, 7'h00, 7'h00);
        #3;
        check("R11 enables unchanged", rdata, 8'h82);

        // R11: rdata is 0 during a selected write
        drive(1'b1, 1'b0, 1'b1, 8'h80, 7'h00, 7'h00, 7'h00);
        #3;
        check("R11 rdata in write", rdata, 8'h00);

        // R8: all sources pending and enabled drive the request
        drive(1'b1, 1'b0, 1'b1, 8'hFF, 7'h7F, 7'h00, 7'h00);
        idle();
        #3;
        check("R8 irq_n all", {7'd0, irq_n}, 8'h00);
        check("R8 irq_oe all", {7'd0, irq_oe}, 8'h01);

        // R1: mid-run reset clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cs = 1'b1; rnw = 1'b1; reg_sel = 1'b0;
        #3;
        check("R1 flags after reset", rdata, 8'h00);
        check("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);
        drive(1'b1, 1'b1, 1'b1, 8'h00, 7'h00, 7'h00, 7'h00);
        #3;
        check("R1 enables after reset", rdata, 8'h80);

        idle();
        finish_run();
    end

endmodule